// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Port

This block is the host-facing configuration port of a chip. It watches a two-wire serial bus (a clock line and an open-drain data line). When a bus master addresses it, it gives that master single-byte read and write access to a bank of 8-bit registers that sits in the surrounding core. The block never drives the data line high. It either pulls the line low or releases it, and an external pull-up supplies the logic 1.

Access works through a pointer. In a write transaction the master first sends a register index, which the block keeps in a pointer flop, and then one data byte. That data byte leaves the block as a one-cycle write strobe together with the pointer and the data. A read begins the same way with the index. The master then issues a repeated START, sends the device address with the read bit set, and the block returns the byte that the core presents for the current pointer. Both bus lines are resynchronised and filtered against short glitches, using the block's own fast clock, before any bus condition is decoded.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is applied and after it is released, `sda_oe` is 0 (line released), `reg_we` is 0 and `reg_addr` is 0x00.
- R2: A STOP condition (data rising while the clock is high) at any point returns the block to idle and releases the line. A transfer cut off this way leaves the pointer and the register bank unchanged. A START or repeated START (data falling while the clock is high) begins a fresh address byte from any state.
- R3: Every byte is sampled on rising clock edges, MSB first, and a ninth clock carries the acknowledge. In the first byte, bits 7:1 are compared with `DEV_ADDR` (default 0x58) and bit 0 selects the direction (1 = master reads, 0 = master writes). On a match the block pulls the line low for the ninth clock.
- R4: When the address does not match, the block does not acknowledge, issues no write strobe and keeps the line released on every clock until the next START.
- R5: In a write, the second byte is acknowledged and loaded into the pointer. The third byte is acknowledged and produces exactly one `reg_we` pulse, one clock cycle wide, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: Any byte after the data byte of a write is not acknowledged and produces no write strobe.
- R7: After an acknowledged read address, the block shifts out `reg_rdata` for the current pointer, MSB first. It changes the line only while the clock is low and releases it after the eighth bit. Whatever the master answers, the line then stays released until the next START or STOP.
- R8: The pointer persists across transactions. `reg_addr` always shows it, and a read with no preceding index write returns the register last pointed at.
- R9: A pulse on either bus line that lasts fewer than `FILT_LEN` clock cycles (default 4) after synchronisation has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (the wired level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 8 | Register pointer toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Core's contents of register `reg_addr` |

## Verification
A wrong bit count or a wrong state shows on the bus at the very next clock-high phase. The acknowledge lands one bit early or late, or the data line is pulled during a bit where the master owns it. Both are visible at the mid-point of that bit. A pointer captured wrongly stays hidden until the next read or write, where it appears as the wrong returned byte or the wrong `reg_addr` with the strobe. A lost or spurious write strobe shows at `reg_we` within a few internal cycles of the falling clock edge that closes the data byte.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int N_LINES   = 2;
    localparam int LINE_SDA  = 0;
    localparam int LINE_SCL  = 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WR,
        ST_ACK_RD,
        ST_PTR,
        ST_ACK_PTR,
        ST_DATA,
        ST_ACK_DATA,
        ST_TX
    } link_state_t;

    // Decoded bus conditions, one clock cycle wide each.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input byte_t b, input logic [BYTE_W-2:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/twi_line_cond.sv
`timescale 1ns/1ps
module twi_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       agree_cnt;
    logic                   synced;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // The output follows only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            line_o    <= 1'b1;
            agree_cnt <= '0;
        end else if (synced == line_o) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CNT_W'(FILT_LEN - 1)) begin
            line_o    <= synced;
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end

    // R9: the filtered level only ever moves to the synchronised level
    a_r9_filter_follows_sync: assert property (@(posedge clk) disable iff (rst)
        $changed(line_o) |-> (line_o == $past(synced)));

endmodule

// File: rtl/twi_bus_events.sv
`timescale 1ns/1ps
module twi_bus_events
    import twi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/twi_proto_fsm.sv
`timescale 1ns/1ps
module twi_proto_fsm
    import twi_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h58
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rdata,
    output logic    sda_oe,
    output byte_t   ptr,
    output byte_t   wdata,
    output logic    we
);
    link_state_t          state;
    byte_t                shreg;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 byte_full;

    assign byte_full = (bit_cnt == BIT_CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            wdata   <= '0;
            we      <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            we <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (ev.scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    state  <= shreg[0] ? ST_ACK_RD : ST_ACK_WR;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_PTR;
                            end else begin
                                wdata  <= shreg;
                                we     <= 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_DATA;
                            end
                        end
                    end
                    ST_ACK_WR: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_PTR;
                    end
                    ST_ACK_PTR: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_DATA;
                    end
                    ST_ACK_DATA: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                    end
                    ST_ACK_RD: if (ev.scl_fall) begin
                        shreg   <= rdata;
                        sda_oe  <= ~rdata[BYTE_W-1];
                        bit_cnt <= BIT_CNT_W'(1);
                        state   <= ST_TX;
                    end
                    ST_TX: if (ev.scl_fall) begin
                        if (byte_full) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_IDLE;
                        end else begin
                            sda_oe  <= ~shreg[BYTE_W-2];
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: the block moves the data line only while the filtered clock is low
    a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_oe) |-> !ev.scl);

    // R5: the write strobe is one cycle wide
    a_r5_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    // R8: the pointer does not move in the cycle the data is handed over
    a_r8_ptr_stable_on_we: assert property (@(posedge clk) disable iff (rst)
        we |-> $stable(ptr));

    // R2: a STOP leaves the block idle with the line released
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && state == ST_IDLE));

    // R4: a foreign address is never acknowledged
    a_r4_mismatch_no_ack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev.scl_fall && byte_full && !ev.start && !ev.stop
         && !addr_hit(shreg, DEV_ADDR)) |=> (!sda_oe && state == ST_IDLE));

    // R6: idle means released
    a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !$past(ev.start)) |-> !sda_oe);

endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h58,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    logic [N_LINES-1:0] raw_l;
    logic [N_LINES-1:0] filt_l;
    bus_ev_t            ev;

    assign raw_l[LINE_SCL] = scl_i;
    assign raw_l[LINE_SDA] = sda_i;

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        twi_line_cond #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_cond (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_l[gi]),
            .line_o (filt_l[gi])
        );
    end

    twi_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_l[LINE_SCL]),
        .sda_f (filt_l[LINE_SDA]),
        .ev    (ev)
    );

    twi_proto_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .rdata  (reg_rdata),
        .sda_oe (sda_oe),
        .ptr    (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we)
    );

endmodule

// File: tb/twi_reg_slave_tb.sv
`timescale 1ns/1ps
module twi_reg_slave_tb;

    localparam int Q = 20;              // clocks per quarter bus bit

    logic clk = 1'b0;
    always #4 clk = ~clk;               // 125 MHz

    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_line = m_sda & ~sda_oe;

    logic [7:0] bank   [0:255];         // core behind the port
    logic [7:0] shadow [0:255];         // expected register contents
    logic [7:0] exp_ptr = 8'h00;
    logic [7:0] q_a [$];
    logic [7:0] q_d [$];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    twi_reg_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];
    always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every clock: each write strobe must match the next expected write.
    always @(negedge clk) begin
        logic [7:0] ea, ed;
        if (!rst && reg_we) begin
            n_chk++;
            if (q_a.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected strobe actual=%0h:%0h expected=none", reg_addr, reg_wdata);
            end else begin
                ea = q_a.pop_front();
                ed = q_d.pop_front();
                if (reg_addr !== ea || reg_wdata !== ed) begin
                    n_fail++;
                    $display("FAIL R5 strobe actual=%0h:%0h expected=%0h:%0h", reg_addr, reg_wdata, ea, ed);
                end
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bit_cycle(input logic mbit, input logic exp_oe, input string tag,
                             input logic glitch, output logic seen);
        m_sda = mbit;
        wait_q();
        m_scl = 1'b1;
        wait_q();
        if (glitch) begin
            m_sda = 1'b0;
            repeat (2) @(posedge clk);
            #1 m_sda = mbit;
            repeat (2) @(posedge clk);
            #1;
        end
        check(tag, 32'(sda_oe), 32'(exp_oe));
        seen = sda_line;
        wait_q();
        m_scl = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic glitch_scl();
        @(posedge clk); #1 m_scl = 1'b1;
        @(posedge clk); #1 m_scl = 1'b0;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, tag, 1'b0, s);
        bit_cycle(1'b1, exp_ack, {tag, " ack"}, 1'b0, s);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] got;
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~exp[i], {tag, " drive"}, 1'b0, s);
            got[i] = s;
        end
        check({tag, " byte"}, 32'(got), 32'(exp));
        bit_cycle(~mack, 1'b0, {tag, " master-ack"}, 1'b0, s);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        send_byte(a, 1'b1, "R5 index");
        exp_ptr = a;
        q_a.push_back(a);
        q_d.push_back(d);
        send_byte(d, 1'b1, "R5 data");
        shadow[a] = d;
        bus_stop();
        check("R8 reg_addr after write", 32'(reg_addr), 32'(a));
    endtask

    task automatic rd_reg(input logic [7:0] a);
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        send_byte(a, 1'b1, "R8 index");
        exp_ptr = a;
        bus_start();
        send_byte(8'hB1, 1'b1, "R3 read address");
        recv_byte(shadow[a], 1'b0, "R7 read");
        bus_stop();
    endtask

    task automatic rd_cur(input string tag);
        bus_start();
        send_byte(8'hB1, 1'b1, "R3 read address");
        recv_byte(shadow[exp_ptr], 1'b0, tag);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) begin
            bank[i]   = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (2) @(posedge clk);
        #1;
        check("R1 sda_oe in reset", 32'(sda_oe), 32'h0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check("R1 sda_oe", 32'(sda_oe), 32'h0);
        check("R1 reg_we", 32'(reg_we), 32'h0);
        check("R1 reg_addr", 32'(reg_addr), 32'h0);

        // R5 / R7: writes with varied patterns, then read back
        wr_reg(8'h10, 8'hA5);
        wr_reg(8'h00, 8'h00);
        wr_reg(8'hFF, 8'hFF);
        wr_reg(8'h7E, 8'h5A);
        rd_reg(8'h10);
        rd_reg(8'h00);
        rd_reg(8'hFF);
        rd_reg(8'h7E);
        rd_reg(8'h33);

        // R8: read without index write uses the held pointer
        rd_cur("R8 current read");
        rd_cur("R8 current read again");

        // R4: foreign write address, then the following byte
        bus_start();
        send_byte(8'h42, 1'b0, "R4 foreign write address");
        send_byte(8'h00, 1'b0, "R4 ignored byte");
        bus_stop();
        // R4: foreign read address, slave must not drive data
        bus_start();
        send_byte(8'hB3, 1'b0, "R4 foreign read address");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, "R4 no drive", 1'b0, s);
        bus_stop();
        check("R4 pointer unchanged", 32'(reg_addr), 32'(exp_ptr));

        // R6: extra byte after the data byte is refused and not written
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        send_byte(8'h20, 1'b1, "R5 index");
        exp_ptr = 8'h20;
        q_a.push_back(8'h20);
        q_d.push_back(8'h11);
        send_byte(8'h11, 1'b1, "R5 data");
        shadow[8'h20] = 8'h11;
        send_byte(8'h22, 1'b0, "R6 extra byte");
        bus_stop();
        rd_reg(8'h20);
        rd_reg(8'h21);

        // R2: STOP inside the index byte leaves the pointer alone
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        for (int i = 7; i >= 4; i--) bit_cycle(8'hC3 >> i, 1'b0, "R2 partial index", 1'b0, s);
        bus_stop();
        check("R2 pointer after abort", 32'(reg_addr), 32'(exp_ptr));
        rd_cur("R2 read after abort");

        // R2: STOP inside the data byte writes nothing
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        send_byte(8'h50, 1'b1, "R5 index");
        exp_ptr = 8'h50;
        for (int i = 7; i >= 4; i--) bit_cycle(8'hEE >> i, 1'b0, "R2 partial data", 1'b0, s);
        bus_stop();
        rd_cur("R2 no write after abort");

        // R2: repeated START restarts a write
        bus_start();
        send_byte(8'hB0, 1'b1, "R3 write address");
        send_byte(8'h40, 1'b1, "R5 index");
        exp_ptr = 8'h40;
        bus_start();
        send_byte(8'hB0, 1'b1, "R2 restart address");
        send_byte(8'h41, 1'b1, "R2 restart index");
        exp_ptr = 8'h41;
        q_a.push_back(8'h41);
        q_d.push_back(8'h77);
        send_byte(8'h77, 1'b1, "R2 restart data");
        shadow[8'h41] = 8'h77;
        bus_stop();
        rd_reg(8'h41);
        rd_reg(8'h40);

        // R7: master acknowledges the read byte; slave stays released
        bus_start();
        send_byte(8'hB1, 1'b1, "R3 read address");
        recv_byte(shadow[exp_ptr], 1'b1, "R7 acked read");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, "R7 released after byte", 1'b0, s);
        bus_stop();

        // R9: short pulses on both lines are ignored
        bus_start();
        send_byte(8'hB0, 1'b1, "R9 write address");
        glitch_scl();
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(8'h60 >> i, 1'b0, "R9 index", (i == 6), s);
            if (i == 3) glitch_scl();
        end
        bit_cycle(1'b1, 1'b1, "R9 index ack", 1'b0, s);
        exp_ptr = 8'h60;
        q_a.push_back(8'h60);
        q_d.push_back(8'h3C);
        send_byte(8'h3C, 1'b1, "R9 data");
        shadow[8'h60] = 8'h3C;
        bus_stop();
        rd_reg(8'h60);

        repeat (20) @(posedge clk);
        #1;
        check("R5 all expected strobes seen", 32'(q_a.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule